// File: doc/BRIEF.md
# Maintenance Channel Change-Detect Register

This block sits in the receive path of a digital subscriber line transceiver. Once per received superframe a maintenance byte arrives with a one-cycle valid strobe. The block keeps a record of the previous received byte and a host-visible held byte. A two-bit policy field decides when the held byte is rewritten:

- **Two-in-a-row agreement:** two identical consecutive bytes that differ from the held value.
- **Change detection:** a byte that differs from the previous one.
- **Unconditional capture:** every byte.

Each rewrite is followed by a one-cycle interrupt pulse. While superframe alignment is lost, the held byte is frozen and no interrupt is raised. The record of the previous byte keeps tracking the line during that time.

The block also forms the transmitted far-end block error bit. This bit is active low. A control input chooses between two sources:

- the host input on its own;
- the merge of the host input with the locally computed near-end error, where either one being active makes the output active.

Top module: `maint_cd_reg`

## Requirements
- R1: After a synchronous reset `held_byte` is all ones, `irq_pulse` is 0 and `febe_tx` is 1.
- R2: With `mode_sel` = 2'b11 (every), each strobed byte received while `sf_sync` is 1 is written to `held_byte`. The new value is visible the cycle after the strobe.
- R3: With `mode_sel` = 2'b10 (delta), a strobed byte with `sf_sync` at 1 is written only if it differs in at least one bit from the previous strobed byte.
- R4: With `mode_sel` = 2'b00 (dual-consecutive), a strobed byte with `sf_sync` at 1 is written only if it equals the previous strobed byte and differs from `held_byte`.
- R5: `mode_sel` = 2'b01 behaves exactly as 2'b00.
- R6: A strobe received while `sf_sync` is 0 leaves `held_byte` unchanged and raises no interrupt. Without a strobe, `held_byte` never changes.
- R7: Strobed bytes received while `sf_sync` is 0 still become the previous byte used by the next comparison.
- R8: Every write of `held_byte` is followed by `irq_pulse` high for exactly one cycle. The pulse comes the cycle after the new value appears (two cycles after the strobe). No pulse occurs without a write.
- R9: With `febe_ctl` = 0, `febe_tx` equals `febe_host` AND `nebe_calc`, since both are active low. The output is registered, one cycle after the inputs.
- R10: With `febe_ctl` = 1, `febe_tx` follows `febe_host`, one cycle after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | DW | Maintenance byte of the current superframe |
| byte_vld | input | 1 | One-cycle strobe marking `byte_in` valid |
| sf_sync | input | 1 | Superframe alignment present |
| mode_sel | input | 2 | Update policy: 00 dual-consecutive, 01 reserved (as 00), 10 delta, 11 every |
| febe_ctl | input | 1 | 0 merges near-end error into febe; 1 passes the host febe |
| nebe_calc | input | 1 | Computed near-end block error, active low |
| febe_host | input | 1 | Host far-end block error request, active low |
| held_byte | output | DW | Host-visible held maintenance byte |
| irq_pulse | output | 1 | One-cycle update interrupt |
| febe_tx | output | 1 | Transmitted far-end block error, active low |

## Verification
The assertions assume that `byte_vld` is never high in two consecutive cycles. This matches one byte per superframe, and the single-cycle interrupt property depends on it. They also take `mode_sel` and `sf_sync` as sampled only on the strobe cycle. The stimulus sends each byte as a one-cycle strobe followed by at least two idle cycles. Byte values are drawn partly by repeating the previous byte, so that the agreement and no-change paths are actually taken.

// File: rtl/maint_cd_pkg.sv
package maint_cd_pkg;

    typedef enum logic [1:0] {
        POL_DUAL  = 2'b00,
        POL_RSVD  = 2'b01,
        POL_DELTA = 2'b10,
        POL_EVERY = 2'b11
    } policy_e;

    typedef struct packed {
        logic same_as_prev;
        logic same_as_held;
        logic in_sync;
        logic strobe;
    } cmp_t;

    // decide whether a strobed byte rewrites the held register
    function automatic logic take_byte(policy_e pol, cmp_t c);
        logic ok;
        case (pol)
            POL_EVERY: ok = 1'b1;
            POL_DELTA: ok = !c.same_as_prev;
            default:   ok = c.same_as_prev && !c.same_as_held;
        endcase
        return ok && c.strobe && c.in_sync;
    endfunction

    // active-low merge of the error sources
    function automatic logic febe_value(logic pass_host, logic host_n, logic nebe_n);
        return pass_host ? host_n : (host_n & nebe_n);
    endfunction

endpackage

// File: rtl/maint_cd_history.sv
module maint_cd_history #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_in,
    output logic [DW-1:0] prev_byte
);
    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            prev_byte <= ONES;
        else if (byte_vld)
            prev_byte <= byte_in;
    end
endmodule

// File: rtl/maint_cd_policy.sv
module maint_cd_policy
    import maint_cd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] byte_in,
    input  logic          byte_vld,
    input  logic          sf_sync,
    input  logic [1:0]    mode_sel,
    input  logic [DW-1:0] prev_byte,
    input  logic [DW-1:0] held_byte,
    output logic          take
);
    cmp_t    c;
    policy_e pol;

    always_comb begin
        pol            = policy_e'(mode_sel);
        c.same_as_prev = (byte_in == prev_byte);
        c.same_as_held = (byte_in == held_byte);
        c.in_sync      = sf_sync;
        c.strobe       = byte_vld;
        take           = take_byte(pol, c);
    end
endmodule

// File: rtl/maint_cd_hold.sv
module maint_cd_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] byte_in,
    output logic [DW-1:0] held_byte,
    output logic          irq_pulse
);
    localparam logic [DW-1:0] ONES = {DW{1'b1}};

    logic wrote_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_byte <= ONES;
            wrote_q   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            if (take)
                held_byte <= byte_in;
            wrote_q   <= take;
            irq_pulse <= wrote_q;
        end
    end
endmodule

// File: rtl/maint_cd_febe.sv
module maint_cd_febe
    import maint_cd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic febe_ctl,
    input  logic nebe_calc,
    input  logic febe_host,
    output logic febe_tx
);
    always_ff @(posedge clk) begin
        if (rst)
            febe_tx <= 1'b1;
        else
            febe_tx <= febe_value(febe_ctl, febe_host, nebe_calc);
    end
endmodule

// File: rtl/maint_cd_reg.sv
module maint_cd_reg
    import maint_cd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] byte_in,
    input  logic          byte_vld,
    input  logic          sf_sync,
    input  logic [1:0]    mode_sel,
    input  logic          febe_ctl,
    input  logic          nebe_calc,
    input  logic          febe_host,
    output logic [DW-1:0] held_byte,
    output logic          irq_pulse,
    output logic          febe_tx
);
    logic [DW-1:0] prev_byte;
    logic          take;

    maint_cd_history #(.DW(DW)) i_hist (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .prev_byte(prev_byte)
    );

    maint_cd_policy #(.DW(DW)) i_pol (
        .byte_in(byte_in), .byte_vld(byte_vld), .sf_sync(sf_sync),
        .mode_sel(mode_sel), .prev_byte(prev_byte), .held_byte(held_byte),
        .take(take)
    );

    maint_cd_hold #(.DW(DW)) i_hold (
        .clk(clk), .rst(rst), .take(take), .byte_in(byte_in),
        .held_byte(held_byte), .irq_pulse(irq_pulse)
    );

    maint_cd_febe i_febe (
        .clk(clk), .rst(rst), .febe_ctl(febe_ctl), .nebe_calc(nebe_calc),
        .febe_host(febe_host), .febe_tx(febe_tx)
    );
endmodule

// File: rtl/maint_cd_chk.sv
module maint_cd_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] byte_in,
    input logic          byte_vld,
    input logic          sf_sync,
    input logic [1:0]    mode_sel,
    input logic          febe_ctl,
    input logic          nebe_calc,
    input logic          febe_host,
    input logic [DW-1:0] held_byte,
    input logic          irq_pulse,
    input logic          febe_tx
);
    // input assumption behind R8: at most one strobe per two cycles
    p_strobe_spaced_r8: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    p_frozen_nosync_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && !sf_sync) |=> $stable(held_byte));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(held_byte));

    p_every_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && sf_sync && mode_sel == 2'b11) |=> held_byte == $past(byte_in));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ($past(byte_vld, 2) && $past(sf_sync, 2)));

    p_febe_merge_r9: assert property (@(posedge clk) disable iff (rst)
        !febe_ctl |=> febe_tx == ($past(febe_host) & $past(nebe_calc)));

    p_febe_pass_r10: assert property (@(posedge clk) disable iff (rst)
        febe_ctl |=> febe_tx == $past(febe_host));
endmodule

bind maint_cd_reg maint_cd_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .sf_sync(sf_sync), .mode_sel(mode_sel), .febe_ctl(febe_ctl),
    .nebe_calc(nebe_calc), .febe_host(febe_host), .held_byte(held_byte),
    .irq_pulse(irq_pulse), .febe_tx(febe_tx)
);

// File: tb/test_maint_cd_reg.sv
`timescale 1ns/1ps
module test_maint_cd_reg;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] byte_in;
    logic          byte_vld;
    logic          sf_sync;
    logic [1:0]    mode_sel;
    logic          febe_ctl, nebe_calc, febe_host;
    logic [DW-1:0] held_byte;
    logic          irq_pulse, febe_tx;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] m_prev, m_held;
    logic          done = 1'b0;

    always #2 clk = ~clk;

    maint_cd_reg #(.DW(DW)) i_maint_cd_reg (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_take(logic [1:0] m, logic [DW-1:0] b, logic s);
        logic ok;
        if (m == 2'b11)      ok = 1'b1;
        else if (m == 2'b10) ok = (b != m_prev);
        else                 ok = (b == m_prev) && (b != m_held);
        return ok && s;
    endfunction

    // one strobe, then check held (next cycle), irq (cycle after), and idle
    task automatic send(logic [DW-1:0] b, logic s, logic [1:0] m, string req);
        logic tk;
        @(negedge clk);
        byte_in = b; byte_vld = 1'b1; sf_sync = s; mode_sel = m;
        tk = model_take(m, b, s);
        m_prev = b;
        if (tk) m_held = b;
        @(negedge clk);
        byte_vld = 1'b0;
        check({req, " held"}, held_byte, m_held);
        check({req, " irq early"}, irq_pulse, 1'b0);
        @(negedge clk);
        check({req, " irq"}, irq_pulse, tk);
        @(negedge clk);
        check({req, " irq width R8"}, irq_pulse, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; byte_in = '0; byte_vld = 1'b0; sf_sync = 1'b1; mode_sel = 2'b00;
        febe_ctl = 1'b0; nebe_calc = 1'b1; febe_host = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 held", held_byte, {DW{1'b1}});
        check("R1 irq", irq_pulse, 1'b0);
        check("R1 febe", febe_tx, 1'b1);
        rst = 1'b0;
        m_prev = '1; m_held = '1;

        // R2 every mode, including a repeat of the same value
        send(8'h3C, 1'b1, 2'b11, "R2");
        send(8'h3C, 1'b1, 2'b11, "R2 repeat");
        // R3 delta mode
        send(8'h3C, 1'b1, 2'b10, "R3 same");
        send(8'h81, 1'b1, 2'b10, "R3 diff");
        // R4 dual-consecutive
        send(8'h55, 1'b1, 2'b00, "R4 first");
        send(8'h55, 1'b1, 2'b00, "R4 second");
        send(8'h55, 1'b1, 2'b00, "R4 equal held");
        // R5 reserved code acts as dual
        send(8'h0F, 1'b1, 2'b01, "R5 first");
        send(8'h0F, 1'b1, 2'b01, "R5 second");
        // R6 frozen without sync in every mode
        send(8'hA0, 1'b0, 2'b11, "R6 every");
        // R7 history tracks during sync loss
        send(8'hB7, 1'b0, 2'b10, "R7 nosync");
        send(8'hB7, 1'b1, 2'b10, "R7 resync same");
        send(8'hC2, 1'b0, 2'b00, "R7 dual nosync");
        send(8'hC2, 1'b1, 2'b00, "R7 dual resync");

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [DW-1:0] b;
            logic s;
            logic [1:0] m;
            b = ($urandom % 3 == 0) ? m_prev : (($urandom % 2) ? m_held : DW'($urandom));
            s = ($urandom % 5) != 0;
            m = 2'($urandom);
            send(b, s, m, "R2-R7 random");
        end

        // R9 / R10 febe
        for (int i = 0; i < 200; i++) begin
            logic c, n, h;
            c = ($urandom % 2) != 0;
            n = ($urandom % 2) != 0;
            h = ($urandom % 2) != 0;
            @(negedge clk);
            febe_ctl = c; nebe_calc = n; febe_host = h;
            @(negedge clk);
            if (c) check("R10 febe pass", febe_tx, h);
            else   check("R9 febe merge", febe_tx, h & n);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule